// File: doc/BRIEF.md
# Rolling-Hash Content Anchor Detector

This block scans a byte stream at one byte per clock and maintains a 64-bit rolling hash over the most recent 4093 bytes. Every accepted byte advances the hash. The previous hash is rotated left by one bit and then XORed with two terms. The first is the combined output of five byte-indexed 64-bit entering tables. The second, once the window has filled, is a leaving table indexed by the byte that entered 4093 positions earlier. The leaving table is loaded as the combined entering table rotated left by 61 bits, which is 4093 mod 64. With that loading, a byte's contribution vanishes exactly when it drops out of the window.

A programmable 64-bit mask selects hash bits, and those bits are compared against a programmable pattern. When they agree, the block presents an anchor record carrying the 0-based byte offset and the full unmasked hash. These anchors mark content-defined chunk boundaries for deduplication. The anchor output uses a valid/ready handshake, and byte intake stalls while a record waits. A run enable gates processing, and a start pulse restarts the hash and the offset count. Table, mask and pattern contents are loaded through one write port while the block is idle.

Top module: `roll_anchor_det`

## Requirements
- R1: After reset, or in the cycle after a start pulse, the hash and the byte count are zero and no anchor record is pending. The byte accepted next has offset 0. No byte is consumed while start is high.
- R2: Each accepted byte b updates the hash to H' = rotl1(H) ^ E0[b] ^ E1[b] ^ E2[b] ^ E3[b] ^ E4[b] ^ Lterm, where rotl1 is a 1-bit left rotation.
- R3: Lterm is zero for the first 4093 bytes after a start. For byte offset n ≥ 4093, Lterm is the leaving-table word indexed by the byte at offset n-4093.
- R4: When the leaving table equals the XOR of the entering tables rotated left by 61, the hash after at least 4093 bytes depends only on the last 4093 bytes.
- R5: A byte whose new hash H' satisfies ((H' ^ pattern) & mask) == 0 produces a record in the following cycle. The record has anc_valid high, anc_offset equal to the byte's 0-based offset, and anc_hash equal to the full H'.
- R6: While anc_valid is high and anc_ready is low, the record holds stable, in_ready is low and no byte is consumed. A byte can be consumed in the same cycle that a record is accepted.
- R7: While run_en is low, in_ready is low and the hash and byte count hold their values.
- R8: Writes to tables, mask or pattern take effect only while run_en is low. Writes made while run_en is high are ignored.
- R9: Reset sets the mask to 64'h3FFF (the 14 low bits) and the pattern to zero.
- R10: wr_sel selects the write target: 0 to 4 select entering tables E0 to E4, 5 selects the leaving table, 6 the mask and 7 the pattern. For tables, wr_addr is the byte index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Restart pulse: clears hash, count, window and pending record |
| run_en | input | 1 | Enables byte processing; low allows configuration writes |
| in_valid | input | 1 | Entering byte is present |
| in_byte | input | 8 | Entering byte |
| in_ready | output | 1 | Byte is consumed this cycle when in_valid is high |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 3 | Write target select |
| wr_addr | input | 8 | Table index |
| wr_data | input | 64 | Write data |
| anc_valid | output | 1 | Anchor record present |
| anc_ready | input | 1 | Consumer accepts the record |
| anc_offset | output | OFS_W | Byte offset of the anchor |
| anc_hash | output | 64 | Unmasked hash at the anchor |

## Verification
A wrong hash state cannot be seen directly, because it surfaces only through anchor records. Programming an all-zero mask turns every byte into an anchor, so a corrupted hash, a wrong rotation or a mistimed leaving byte appears in anc_hash on the very next record. An off-by-one leaving-byte alignment appears first at offset 4093. A count error appears as a wrong anc_offset on the next record. Stall and idle faults appear as in_ready disagreeing in the same cycle, or as a lost or duplicated byte in the next record.

// File: rtl/rad_pkg.sv
package rad_pkg;
    localparam int HASH_W    = 64;
    localparam int BYTE_W    = 8;
    localparam int TBL_DEPTH = 1 << BYTE_W;
    localparam int N_ENTER   = 5;
    localparam int SEL_W     = 3;

    typedef logic [HASH_W-1:0] hash_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_E0   = 3'd0,
        SEL_E1   = 3'd1,
        SEL_E2   = 3'd2,
        SEL_E3   = 3'd3,
        SEL_E4   = 3'd4,
        SEL_EXIT = 3'd5,
        SEL_MASK = 3'd6,
        SEL_PAT  = 3'd7
    } wsel_e;

    typedef struct packed {
        logic  en;
        wsel_e sel;
        byte_t addr;
        hash_t data;
    } wr_cmd_t;

    localparam hash_t DEF_MASK = 64'h0000_0000_0000_3FFF;
    localparam hash_t DEF_PAT  = '0;

    function automatic hash_t rotl1(input hash_t h);
        return {h[HASH_W-2:0], h[HASH_W-1]};
    endfunction
endpackage

// File: rtl/rad_tables.sv
module rad_tables
    import rad_pkg::*;
(
    input  logic    clk,
    input  wr_cmd_t wr,
    input  byte_t   enter_byte,
    input  byte_t   leave_byte,
    output hash_t   enter_mix,
    output hash_t   leave_mix
);
    hash_t rd [N_ENTER+1];

    for (genvar k = 0; k <= N_ENTER; k++) begin : g_tbl
        hash_t mem [TBL_DEPTH];

        always_ff @(posedge clk) begin
            if (wr.en && wr.sel == wsel_e'(k))
                mem[wr.addr] <= wr.data;
        end

        if (k < N_ENTER) begin : g_enter
            assign rd[k] = mem[enter_byte];
        end else begin : g_leave
            assign rd[k] = mem[leave_byte];
        end
    end

    always_comb begin
        enter_mix = '0;
        for (int k = 0; k < N_ENTER; k++)
            enter_mix = enter_mix ^ rd[k];
    end

    assign leave_mix = rd[N_ENTER];
endmodule

// File: rtl/rad_window.sv
module rad_window
    import rad_pkg::*;
#(
    parameter int DEPTH = 4093
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  push,
    input  byte_t din,
    output byte_t dout,
    output logic  full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    byte_t            ring [DEPTH];
    logic [PTR_W-1:0] ptr;

    assign dout = ring[ptr];

    always_ff @(posedge clk) begin
        if (push && !clear)
            ring[ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ptr  <= '0;
            full <= 1'b0;
        end else if (push) begin
            if (ptr == LAST) begin
                ptr  <= '0;
                full <= 1'b1;
            end else begin
                ptr <= ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rad_match.sv
module rad_match
    import rad_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_cmd_t wr,
    input  hash_t   hash_in,
    output logic    hit
);
    hash_t mask_q;
    hash_t pat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= DEF_MASK;
            pat_q  <= DEF_PAT;
        end else if (wr.en) begin
            if (wr.sel == SEL_MASK) mask_q <= wr.data;
            if (wr.sel == SEL_PAT)  pat_q  <= wr.data;
        end
    end

    assign hit = ((hash_in ^ pat_q) & mask_q) == '0;
endmodule

// File: rtl/roll_anchor_det.sv
module roll_anchor_det
    import rad_pkg::*;
#(
    parameter int WINDOW = 4093,
    parameter int OFS_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run_en,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [7:0]       wr_addr,
    input  logic [63:0]      wr_data,
    output logic             anc_valid,
    input  logic             anc_ready,
    output logic [OFS_W-1:0] anc_offset,
    output logic [63:0]      anc_hash
);
    wr_cmd_t          wr;
    hash_t            hash_q, hash_nxt, enter_mix, leave_mix, leave_term;
    byte_t            old_byte;
    logic             win_full, take, hit, out_free;
    logic [OFS_W-1:0] cnt_q;

    // configuration is only accepted while the datapath is idle
    assign wr.en   = wr_en && !run_en;
    assign wr.sel  = wsel_e'(wr_sel);
    assign wr.addr = wr_addr;
    assign wr.data = wr_data;

    assign out_free = !anc_valid || anc_ready;
    assign in_ready = run_en && !start && out_free;
    assign take     = in_valid && in_ready;

    rad_tables u_tables (
        .clk        (clk),
        .wr         (wr),
        .enter_byte (in_byte),
        .leave_byte (old_byte),
        .enter_mix  (enter_mix),
        .leave_mix  (leave_mix)
    );

    rad_window #(.DEPTH(WINDOW)) u_window (
        .clk   (clk),
        .rst   (rst),
        .clear (start),
        .push  (take),
        .din   (in_byte),
        .dout  (old_byte),
        .full  (win_full)
    );

    assign leave_term = win_full ? leave_mix : '0;
    assign hash_nxt   = rotl1(hash_q) ^ enter_mix ^ leave_term;

    rad_match u_match (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .hash_in (hash_nxt),
        .hit     (hit)
    );

    always_ff @(posedge clk) begin
        if (rst || start) begin
            hash_q     <= '0;
            cnt_q      <= '0;
            anc_valid  <= 1'b0;
            anc_offset <= '0;
            anc_hash   <= '0;
        end else begin
            if (take) begin
                hash_q <= hash_nxt;
                cnt_q  <= cnt_q + 1'b1;
            end
            if (take && hit) begin
                anc_valid  <= 1'b1;
                anc_offset <= cnt_q;
                anc_hash   <= hash_nxt;
            end else if (anc_ready) begin
                anc_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rad_chk.sv
module rad_chk #(
    parameter int OFS_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             run_en,
    input logic             in_valid,
    input logic             in_ready,
    input logic             anc_valid,
    input logic             anc_ready,
    input logic [OFS_W-1:0] anc_offset,
    input logic [63:0]      anc_hash,
    input logic [63:0]      hash_q,
    input logic [OFS_W-1:0] cnt_q
);
    p_start_clear_r1: assert property (@(posedge clk) disable iff (rst)
        start |=> (hash_q == '0 && cnt_q == '0 && !anc_valid));

    p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> cnt_q == $past(cnt_q) + 1'b1);

    p_record_offset_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(anc_valid) |-> anc_offset == cnt_q - 1'b1);

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (anc_valid && !anc_ready && !start) |=>
            (anc_valid && $stable(anc_offset) && $stable(anc_hash)));

    p_stall_block_r6: assert property (@(posedge clk) disable iff (rst)
        (anc_valid && !anc_ready) |-> !in_ready);

    p_idle_block_r7: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> !in_ready);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !start) |=> ($stable(hash_q) && $stable(cnt_q)));
endmodule

bind roll_anchor_det rad_chk #(.OFS_W(OFS_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .run_en     (run_en),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .anc_valid  (anc_valid),
    .anc_ready  (anc_ready),
    .anc_offset (anc_offset),
    .anc_hash   (anc_hash),
    .hash_q     (hash_q),
    .cnt_q      (cnt_q)
);

// File: tb/test_roll_anchor_det.sv
module test_roll_anchor_det;
    localparam int W     = 4093;
    localparam int OFS_W = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0, run_en = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_byte = '0;
    logic             in_ready;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_sel = '0;
    logic [7:0]       wr_addr = '0;
    logic [63:0]      wr_data = '0;
    logic             anc_valid, anc_ready = 1'b1;
    logic [OFS_W-1:0] anc_offset;
    logic [63:0]      anc_hash;

    roll_anchor_det #(.WINDOW(W), .OFS_W(OFS_W)) i_roll_anchor_det (.*);

    always #10 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model
    logic [63:0] et [5][256];
    logic [63:0] lt [256];
    logic [63:0] m_mask = 64'h3FFF, m_pat = '0, mh = '0;
    logic [7:0]  hist [16384];
    int          n = 0;
    bit          ev = 0;
    int          eoff = 0;
    logic [63:0] ehash = '0;

    function automatic logic [63:0] rl1(input logic [63:0] h);
        return {h[62:0], h[63]};
    endfunction

    function automatic logic [63:0] rl61(input logic [63:0] h);
        return {h[2:0], h[63:3]};
    endfunction

    function automatic logic [63:0] tv(input int k, input int a);
        logic [63:0] x;
        x = 64'h9E37_79B9_7F4A_7C15 * 64'(k * 256 + a + 1);
        x = x ^ (x >> 29);
        x = x * 64'hBF58_476D_1CE4_E5B9;
        return x ^ (x >> 32);
    endfunction

    function automatic logic [7:0] cb(input int i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one clock: called just after a negedge, returns just after the next negedge
    task automatic step(input logic v, input logic [7:0] b, input string req);
        bit rdy;
        logic [63:0] e, nh;
        in_valid = v;
        in_byte  = b;
        #1;
        rdy = run_en && !start && (!ev || anc_ready);
        chk(in_ready === rdy, req, "in_ready", 64'(in_ready), 64'(rdy));
        @(posedge clk);
        if (wr_en && !run_en) begin
            if (wr_sel < 3'd5) et[wr_sel][wr_addr] = wr_data;
            else if (wr_sel == 3'd5) lt[wr_addr] = wr_data;
            else if (wr_sel == 3'd6) m_mask = wr_data;
            else m_pat = wr_data;
        end
        if (start) begin
            mh = '0; n = 0; ev = 0;
        end else if (v && rdy) begin
            e = et[0][b] ^ et[1][b] ^ et[2][b] ^ et[3][b] ^ et[4][b];
            nh = rl1(mh) ^ e ^ ((n >= W) ? lt[hist[n - W]] : 64'h0);
            mh = nh;
            hist[n] = b;
            if (((nh ^ m_pat) & m_mask) == '0) begin
                ev = 1; eoff = n; ehash = nh;
            end else if (anc_ready) ev = 0;
            n++;
        end else if (anc_ready) ev = 0;
        @(negedge clk);
        in_valid = 1'b0;
        chk(anc_valid === ev, req, "anc_valid", 64'(anc_valid), 64'(ev));
        if (ev) begin
            chk(anc_offset === OFS_W'(eoff), req, "anc_offset", 64'(anc_offset), 64'(eoff));
            chk(anc_hash === ehash, req, "anc_hash", anc_hash, ehash);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] a,
                      input logic [63:0] d, input string req);
        wr_en = 1'b1; wr_sel = s; wr_addr = a; wr_data = d;
        step(1'b0, 8'h0, req);
        wr_en = 1'b0;
    endtask

    task automatic do_start();
        start = 1'b1;
        step(1'b0, 8'h0, "R1");
        start = 1'b0;
    endtask

    task automatic t_reset();
        chk(anc_valid === 1'b0, "R1", "anc_valid after reset", 64'(anc_valid), 0);
        chk(in_ready === 1'b0, "R1", "in_ready after reset", 64'(in_ready), 0);
    endtask

    task automatic t_load_tables();
        for (int a = 0; a < 256; a++) begin
            logic [63:0] v [5];
            logic [63:0] e;
            e = '0;
            for (int k = 0; k < 5; k++) begin
                v[k] = tv(k, a);
                e = e ^ v[k];
            end
            if (a == 8'h11) begin
                v[0] = v[0] ^ (e & 64'h3FFF);
                e = e ^ (e & 64'h3FFF);
            end
            for (int k = 0; k < 5; k++) wr(3'(k), 8'(a), v[k], "R10");
            wr(3'd5, 8'(a), rl61(e), "R10");
        end
    endtask

    task automatic t_default_cfg();
        run_en = 1'b1;
        do_start();
        step(1'b1, 8'h11, "R9");
        chk(anc_valid === 1'b1, "R9", "default mask anchor", 64'(anc_valid), 1);
        for (int i = 0; i < 300; i++) step(1'b1, 8'($urandom), "R9");
        run_en = 1'b0;
    endtask

    task automatic t_hash_window();
        wr(3'd6, 8'h0, 64'h0, "R10");
        run_en = 1'b1;
        do_start();
        for (int i = 0; i < W + 300; i++)
            step(1'b1, 8'($urandom), (n >= W) ? "R3" : "R2");
        run_en = 1'b0;
    endtask

    task automatic t_window_independence();
        logic [63:0] ha;
        run_en = 1'b1;
        do_start();
        for (int i = 0; i < 100; i++) step(1'b1, 8'($urandom), "R4");
        for (int i = 0; i < W; i++) step(1'b1, cb(i), "R4");
        ha = anc_hash;
        do_start();
        for (int i = 0; i < 37; i++) step(1'b1, 8'(i * 5 + 1), "R4");
        for (int i = 0; i < W; i++) step(1'b1, cb(i), "R4");
        chk(anc_hash === ha, "R4", "hash after same window", anc_hash, ha);
        run_en = 1'b0;
    endtask

    task automatic t_pattern();
        int seen;
        wr(3'd6, 8'h0, 64'hFF, "R5");
        wr(3'd7, 8'h0, 64'h5A, "R5");
        run_en = 1'b1;
        do_start();
        seen = 0;
        for (int i = 0; i < 3000; i++) begin
            step(1'b1, 8'($urandom), "R5");
            if (anc_valid) begin
                seen++;
                chk(anc_hash[7:0] === 8'h5A, "R5", "masked bits", 64'(anc_hash[7:0]), 64'h5A);
            end
        end
        chk(seen > 0, "R5", "anchors seen", 64'(seen), 1);
        run_en = 1'b0;
        wr(3'd6, 8'h0, 64'h0, "R5");
    endtask

    task automatic t_backpressure();
        run_en = 1'b1;
        do_start();
        anc_ready = 1'b0;
        step(1'b1, 8'h21, "R6");
        for (int i = 0; i < 4; i++) step(1'b1, 8'h42, "R6");
        anc_ready = 1'b1;
        step(1'b1, 8'h42, "R6");
        chk(anc_offset === 1, "R6", "offset after stall", 64'(anc_offset), 1);
        run_en = 1'b0;
    endtask

    task automatic t_idle();
        int o;
        run_en = 1'b1;
        do_start();
        for (int i = 0; i < 10; i++) step(1'b1, 8'($urandom), "R7");
        o = int'(anc_offset);
        run_en = 1'b0;
        for (int i = 0; i < 5; i++) step(1'b1, 8'h77, "R7");
        run_en = 1'b1;
        step(1'b1, 8'h33, "R7");
        chk(anc_offset === OFS_W'(o + 1), "R7", "offset after idle", 64'(anc_offset), 64'(o + 1));
        run_en = 1'b0;
    endtask

    task automatic t_busy_writes();
        run_en = 1'b1;
        do_start();
        step(1'b1, 8'h10, "R8");
        wr(3'd6, 8'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
        wr(3'd7, 8'h0, 64'h1234_5678_9ABC_DEF1, "R8");
        wr(3'd0, 8'h55, 64'hDEAD_BEEF_0000_0001, "R8");
        step(1'b1, 8'h55, "R8");
        chk(anc_valid === 1'b1, "R8", "mask write ignored", 64'(anc_valid), 1);
        run_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load_tables();
        t_default_cfg();
        t_hash_window();
        t_window_independence();
        t_pattern();
        t_backpressure();
        t_idle();
        t_busy_writes();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule